// File: doc/BRIEF.md
# DMA Channel Transfer Counter with Half-Completion Flag

This block keeps track of how many transfers a single DMA channel still has to make, and it tells the CPU when half of them are done. Software writes a transfer count into the count register. It then sets the run bit in the control register. Each time the bus side reports that a read cycle has completed, the remaining count goes down by one. When the count reaches zero the channel stops by itself and raises a done bit.

At start, the block latches a half point equal to the loaded count shifted right by one bit. A loaded count of zero stands for 16,777,216 transfers, so its half point is 0x800000. When a completed read brings the remaining count down to that half point, and the half-interrupt enable bit is set, a sticky half flag sets. The flag together with the enable drives an interrupt request. Software clears the flag only by first reading the control register while the flag shows 1, and then writing 0 to the flag bit.

A transfer can be cut short by a non-maskable interrupt, a bus address error, a drop of the global master enable, or software clearing the run bit. An abort that comes before the half point leaves the flag clear. An abort that comes after the flag has set leaves it set.

Top module: `dma_halfend_ctr`

## Requirements
- R1: After reset the count register (select 0) reads 0, the control register (select 1) reads 0 and `irq_half` is 0.
- R2: A control write with bit 0 = 1 starts the channel only when the channel is idle, `master_en` is 1, and neither `nmi_abort` nor `addr_err` is asserted. Starting clears done (bit 1) and sets run (bit 0) on the next cycle.
- R3: While the channel runs, each cycle with `rd_done` = 1 lowers the count read back at select 0 by one on the next cycle. While the channel is idle, `rd_done` leaves the count unchanged.
- R4: Half flag (control bit 3) sets on the completed read that brings the remaining count to the loaded count shifted right by one (N/2 for even N, (N-1)/2 for odd N), only if enable (bit 2) is 1 at that moment. It reads 0 while the count is above that point.
- R5: `irq_half` is 1 exactly when the half flag and the half-interrupt enable are both 1.
- R6: Any of `nmi_abort`, `addr_err`, `master_en` = 0, or a control write with bit 0 = 0 stops a running channel on the next cycle. An abort takes priority over a `rd_done` in the same cycle, and no decrement happens. An abort before the half point leaves the flag at 0, and one after it leaves the flag at 1.
- R7: The half flag clears only on a control write with bit 3 = 0 that follows a control read (`reg_rd`, select 1) which returned bit 3 = 1. Any control write cancels that armed state. Writing 1 to bit 3 never sets the flag.
- R8: The completed read that brings the count to zero sets done (bit 1) and clears run. Further `rd_done` pulses leave the count at 0.
- R9: A loaded count of 0 runs 16,777,216 transfers: after the first completed read the count reads 0xFFFFFF and the channel still runs. The half point is 0x800000.
- R10: Writes to the count register while the channel runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_sel | input | 1 | Register select: 0 count, 1 control |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register |
| rd_done | input | 1 | One transfer's read cycle has completed |
| nmi_abort | input | 1 | Non-maskable interrupt abort |
| addr_err | input | 1 | Address error abort |
| master_en | input | 1 | Global DMA enable; 0 aborts |
| irq_half | output | 1 | Half-completion interrupt request |

## Verification
Every register effect of a stimulus is due one cycle after the clock edge that samples it. Because `reg_rdata` is a combinational view of the selected register, and `irq_half` is a combinational product of two flops, both show the new state in that same following cycle. The bench drives inputs just after a falling edge, lets one rising edge pass, and samples at the next falling edge. Its behavioural model advances on the same edge, so expected and actual values are compared for the same cycle. Directed checks peek at the registers by setting the select without a read strobe, so the peek itself cannot arm flag clearing.

// File: rtl/dma_hec_pkg.sv
package dma_hec_pkg;

  // control register bit positions
  localparam int CTL_RUN   = 0;
  localparam int CTL_DONE  = 1;
  localparam int CTL_HIE   = 2;
  localparam int CTL_HFLAG = 3;

  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_CTRL  = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/dma_hec_count.sv
module dma_hec_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             start_ev,
  input  logic             abort_ev,
  input  logic             rd_done,
  output logic [CNT_W:0]   rem_q,
  output logic [CNT_W:0]   thr_q,
  output logic             run_q,
  output logic             done_q,
  output logic             step_ev,
  output logic             end_ev,
  output logic             half_hit
);
  localparam int REM_W = CNT_W + 1;

  // zero loaded means the full 2**CNT_W transfers
  function automatic logic [REM_W-1:0] expand_count(input logic [REM_W-1:0] r);
    return (r == '0) ? {1'b1, {CNT_W{1'b0}}} : r;
  endfunction

  function automatic logic [REM_W-1:0] half_point(input logic [REM_W-1:0] n);
    return n >> 1;
  endfunction

  logic [REM_W-1:0] rem_dec;

  assign rem_dec  = rem_q - 1'b1;
  assign step_ev  = run_q & rd_done & ~abort_ev;
  assign end_ev   = step_ev & (rem_dec == '0);
  assign half_hit = step_ev & (rem_dec == thr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (cnt_wr) begin
      rem_q <= {1'b0, cnt_wdata};
    end else if (start_ev) begin
      rem_q <= expand_count(rem_q);
    end else if (step_ev) begin
      rem_q <= rem_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (start_ev) begin
      thr_q <= half_point(expand_count(rem_q));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_ev) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      if (abort_ev || end_ev) run_q <= 1'b0;
      if (end_ev)             done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_hec_flag.sv
module dma_hec_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic half_hit,
  input  logic hie_q,
  input  logic ctrl_wr,
  input  logic wr_flag_bit,
  input  logic rd_ctrl,
  output logic flag_q,
  output logic arm_q,
  output logic set_ev,
  output logic clr_ev
);

  assign set_ev = half_hit & hie_q;
  assign clr_ev = ctrl_wr & ~wr_flag_bit & arm_q;

  // sticky flag: a set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_ev) begin
      flag_q <= 1'b1;
    end else if (clr_ev) begin
      flag_q <= 1'b0;
    end
  end

  // armed by reading the flag as 1, dropped by any control write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else if (ctrl_wr) begin
      arm_q <= 1'b0;
    end else if (rd_ctrl && flag_q) begin
      arm_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_halfend_ctr.sv
module dma_halfend_ctr
  import dma_hec_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rd_done,
  input  logic              nmi_abort,
  input  logic              addr_err,
  input  logic              master_en,
  output logic              irq_half
);
  localparam int REM_W = CNT_W + 1;

  reg_sel_e         sel;
  logic             ctrl_wr_ev;
  logic             cnt_wr_ev;
  logic             rd_ctrl_ev;
  logic             start_ev;
  logic             abort_ev;
  logic             step_ev;
  logic             end_ev;
  logic             half_hit;
  logic             set_ev;
  logic             clr_ev;
  logic             hie_q;
  logic             flag_q;
  logic             arm_q;
  logic             run_q;
  logic             done_q;
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] thr_q;

  assign sel        = reg_sel_e'(reg_sel);
  assign ctrl_wr_ev = reg_wr & (sel == SEL_CTRL);
  assign cnt_wr_ev  = reg_wr & (sel == SEL_COUNT) & ~run_q;
  assign rd_ctrl_ev = reg_rd & (sel == SEL_CTRL);

  assign start_ev = ~run_q & ctrl_wr_ev & reg_wdata[CTL_RUN]
                  & master_en & ~nmi_abort & ~addr_err;
  assign abort_ev = run_q & (nmi_abort | addr_err | ~master_en
                  | (ctrl_wr_ev & ~reg_wdata[CTL_RUN]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hie_q <= 1'b0;
    end else if (ctrl_wr_ev) begin
      hie_q <= reg_wdata[CTL_HIE];
    end
  end

  dma_hec_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_wr    (cnt_wr_ev),
    .cnt_wdata (reg_wdata[CNT_W-1:0]),
    .start_ev  (start_ev),
    .abort_ev  (abort_ev),
    .rd_done   (rd_done),
    .rem_q     (rem_q),
    .thr_q     (thr_q),
    .run_q     (run_q),
    .done_q    (done_q),
    .step_ev   (step_ev),
    .end_ev    (end_ev),
    .half_hit  (half_hit)
  );

  dma_hec_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_hit    (half_hit),
    .hie_q       (hie_q),
    .ctrl_wr     (ctrl_wr_ev),
    .wr_flag_bit (reg_wdata[CTL_HFLAG]),
    .rd_ctrl     (rd_ctrl_ev),
    .flag_q      (flag_q),
    .arm_q       (arm_q),
    .set_ev      (set_ev),
    .clr_ev      (clr_ev)
  );

  assign irq_half = flag_q & hie_q;

  always_comb begin
    reg_rdata = '0;
    if (sel == SEL_COUNT) begin
      reg_rdata[CNT_W-1:0] = rem_q[CNT_W-1:0];
    end else begin
      reg_rdata[CTL_RUN]   = run_q;
      reg_rdata[CTL_DONE]  = done_q;
      reg_rdata[CTL_HIE]   = hie_q;
      reg_rdata[CTL_HFLAG] = flag_q;
    end
  end

endmodule

// File: rtl/dma_hec_checker.sv
module dma_hec_checker #(
  parameter int CNT_W = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_half,
  input logic           hie_q,
  input logic           flag_q,
  input logic           arm_q,
  input logic           run_q,
  input logic           done_q,
  input logic [CNT_W:0] rem_q,
  input logic [CNT_W:0] thr_q,
  input logic           start_ev,
  input logic           abort_ev,
  input logic           step_ev,
  input logic           end_ev,
  input logic           cnt_wr_ev,
  input logic           ctrl_wr_ev,
  input logic           clr_ev
);

  a_r3_step_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> rem_q == $past(rem_q) - 1'b1);

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr_ev && !start_ev) |=> $stable(rem_q));

  a_r4_rise_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(step_ev) && rem_q == thr_q && $past(hie_q)));

  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_half |-> (hie_q && flag_q));

  a_r6_abort_early_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ev && !flag_q) |=> !flag_q);

  a_r6_abort_late_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ev && flag_q && !clr_ev) |=> flag_q);

  a_r7_fall_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ctrl_wr_ev && arm_q));

  a_r8_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
    end_ev |=> (!run_q && done_q && rem_q == '0));

  a_r9_full_count_half: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && rem_q == '0) |=> thr_q == {2'b01, {(CNT_W-1){1'b0}}});

endmodule

bind dma_halfend_ctr dma_hec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_half   (irq_half),
  .hie_q      (hie_q),
  .flag_q     (flag_q),
  .arm_q      (arm_q),
  .run_q      (run_q),
  .done_q     (done_q),
  .rem_q      (rem_q),
  .thr_q      (thr_q),
  .start_ev   (start_ev),
  .abort_ev   (abort_ev),
  .step_ev    (step_ev),
  .end_ev     (end_ev),
  .cnt_wr_ev  (cnt_wr_ev),
  .ctrl_wr_ev (ctrl_wr_ev),
  .clr_ev     (clr_ev)
);

// File: tb/dma_halfend_ctr_bench.sv
`timescale 1ns/1ps
module dma_halfend_ctr_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rd_done = 1'b0;
  logic        nmi_abort = 1'b0;
  logic        addr_err = 1'b0;
  logic        master_en = 1'b1;
  logic        irq_half;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  // behavioural model state
  int m_rem = 0, m_thr = 0;
  bit m_run = 0, m_done = 0, m_ie = 0, m_flag = 0, m_arm = 0;

  always #10 clk = ~clk;

  dma_halfend_ctr u_dma_halfend_ctr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rd_done(rd_done), .nmi_abort(nmi_abort), .addr_err(addr_err),
    .master_en(master_en), .irq_half(irq_half)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_view(input bit s);
    if (s) return {28'd0, m_flag, m_ie, m_done, m_run};
    return m_rem & 32'h00FF_FFFF;
  endfunction

  // one cycle: drive, rising edge, advance model, falling edge, compare
  task automatic cyc(input bit wr, input bit rd, input bit s, input logic [31:0] wd,
                     input bit rdd, input bit nmi, input bit aerr, input bit men);
    bit ctrlw, cntw, abrt, strt, stp, hit, clr;
    int full;
    reg_wr = wr; reg_rd = rd; reg_sel = s; reg_wdata = wd;
    rd_done = rdd; nmi_abort = nmi; addr_err = aerr; master_en = men;
    @(posedge clk);
    ctrlw = wr && s;
    cntw  = wr && !s && !m_run;
    abrt  = m_run && (nmi || aerr || !men || (ctrlw && !wd[0]));
    strt  = !m_run && ctrlw && wd[0] && men && !nmi && !aerr;
    stp   = m_run && rdd && !abrt;
    hit   = stp && (m_rem - 1 == m_thr) && m_ie;
    clr   = ctrlw && !wd[3] && m_arm;
    full  = (m_rem == 0) ? (1 << 24) : m_rem;
    m_arm = ctrlw ? 1'b0 : ((rd && s && m_flag) ? 1'b1 : m_arm);
    m_flag = hit ? 1'b1 : (clr ? 1'b0 : m_flag);
    m_ie  = ctrlw ? wd[2] : m_ie;
    if (strt) begin
      m_thr = full / 2; m_rem = full; m_run = 1; m_done = 0;
    end else if (cntw) begin
      m_rem = wd & 32'h00FF_FFFF;
    end else if (stp) begin
      m_rem = m_rem - 1;
      if (m_rem == 0) begin m_run = 0; m_done = 1; end
    end
    if (abrt) m_run = 0;
    @(negedge clk);
    chk("R3 model rdata", reg_rdata, model_view(s));
    chk("R5 model irq", {31'd0, irq_half}, {31'd0, m_flag & m_ie});
    reg_wr = 0; reg_rd = 0; rd_done = 0; nmi_abort = 0; addr_err = 0; master_en = 1;
  endtask

  task automatic idle();                  cyc(0,0,0,0,0,0,0,1); endtask
  task automatic wr_cnt(input int v);     cyc(1,0,0,v,0,0,0,1); endtask
  task automatic wr_ctl(input int v);     cyc(1,0,1,v,0,0,0,1); endtask
  task automatic rd_ctl();                cyc(0,1,1,0,0,0,0,1); endtask
  task automatic xfer();                  cyc(0,0,0,0,1,0,0,1); endtask

  task automatic peek(input bit s, output logic [31:0] v);
    reg_sel = s; reg_wr = 0; reg_rd = 0;
    #1;
    v = reg_rdata;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(0, v); chk("R1 count after reset", v, 0);
    peek(1, v); chk("R1 ctrl after reset", v, 0);
    chk("R1 irq after reset", {31'd0, irq_half}, 0);

    // even count 10, half point 5
    wr_cnt(10); wr_ctl(5);
    peek(1, v); chk("R2 started", v, 32'h5);
    for (int i = 0; i < 4; i++) begin xfer(); idle(); end
    peek(0, v); chk("R3 count after 4", v, 6);
    peek(1, v); chk("R4 flag low above half", v, 32'h5);
    xfer();
    peek(0, v); chk("R4 count at half", v, 5);
    peek(1, v); chk("R4 flag set at N/2", v, 32'hD);
    chk("R5 irq raised", {31'd0, irq_half}, 1);
    wr_cnt(99);
    peek(0, v); chk("R10 count write ignored", v, 5);
    wr_ctl(4);
    peek(1, v); chk("R6 late abort keeps flag", v, 32'hC);
    xfer();
    peek(0, v); chk("R3 idle no decrement", v, 5);

    // clearing rules
    wr_ctl(4);
    peek(1, v); chk("R7 write0 without read", v, 32'hC);
    rd_ctl(); wr_ctl(32'hC);
    peek(1, v); chk("R7 write1 ignored", v, 32'hC);
    wr_ctl(4);
    peek(1, v); chk("R7 arm cancelled by write", v, 32'hC);
    rd_ctl(); wr_ctl(4);
    peek(1, v); chk("R7 read1 then write0 clears", v, 32'h4);
    chk("R5 irq drops", {31'd0, irq_half}, 0);

    // odd count 7, half point 3
    wr_cnt(7); wr_ctl(5);
    for (int i = 0; i < 3; i++) xfer();
    peek(1, v); chk("R4 odd flag low at 4", v, 32'h5);
    xfer();
    peek(0, v); chk("R4 odd count 3", v, 3);
    peek(1, v); chk("R4 odd flag at (N-1)/2", v, 32'hD);
    rd_ctl(); wr_ctl(5);
    peek(1, v); chk("R7 clear while running", v, 32'h5);
    for (int i = 0; i < 3; i++) xfer();
    peek(0, v); chk("R8 count zero", v, 0);
    peek(1, v); chk("R8 done and stopped", v, 32'h6);
    xfer();
    peek(0, v); chk("R8 no further decrement", v, 0);

    // enable off across half point
    wr_cnt(4); wr_ctl(1);
    xfer(); xfer();
    peek(1, v); chk("R4 no flag when disabled", v, 32'h1);
    wr_ctl(5); xfer();
    peek(0, v); chk("R3 count 1", v, 1);
    cyc(0,0,1,0,0,1,0,1);
    peek(1, v); chk("R6 nmi abort", v, 32'h4);

    // early aborts
    wr_cnt(8); wr_ctl(5); xfer();
    cyc(0,0,0,0,1,0,1,1);
    peek(0, v); chk("R6 abort beats rd_done", v, 7);
    peek(1, v); chk("R6 early abort flag clear", v, 32'h4);
    wr_ctl(5); xfer();
    cyc(0,0,1,0,0,0,0,0);
    peek(1, v); chk("R6 master enable abort", v, 32'h4);
    cyc(1,0,1,5,0,0,0,0);
    peek(1, v); chk("R2 no start without master", v, 32'h4);

    // full count
    wr_cnt(0); wr_ctl(5); xfer();
    peek(0, v); chk("R9 zero load wraps", v, 32'hFF_FFFF);
    peek(1, v); chk("R9 still running", v, 32'h5);
    wr_ctl(4);

    // single transfer: half and end together
    wr_cnt(1); wr_ctl(5); xfer();
    peek(1, v); chk("R4 R8 count one", v, 32'hE);
    chk("R5 irq count one", {31'd0, irq_half}, 1);
    rd_ctl(); wr_ctl(4);

    // mixed stimulus against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit w, rd, s, men, nmi, ae;
      logic [31:0] wd;
      r   = $urandom;
      w   = (r[2:0] == 3'd0);
      rd  = !w && (r[4:3] == 2'd0);
      s   = r[5];
      men = (r[11:6] != 6'd0);
      nmi = (r[17:12] == 6'd0);
      ae  = (r[23:18] == 6'd0);
      wd  = s ? {28'd0, r[27:24]} : (r[31:28] % 12);
      cyc(w, rd, s, wd, r[25] | r[26], nmi, ae, men);
    end

    finish_run();
  end

endmodule